// File: doc/BRIEF.md
# Repeated-Subtraction Divider with Remainder

This block divides an unsigned dividend by a small unsigned divisor. It takes the divisor away from a running value once per clock and counts each time the result stays non-negative. The carry-out of a ripple subtractor is the sign test. When that carry shows that the next difference would be negative, the loop stops. The count is then the quotient, and the value left in the running register is the remainder.

The operands are loaded while the start input is low. Raising start captures both operands and launches the loop. The done output marks a valid result for as long as start stays high, and it clears once start is lowered. A zero divisor does not enter the loop. It raises an error flag and reports done straight away, with both results forced to zero. The divisor is 7 bits wide. The expected operating range goes up to 99, but every 7-bit value from 1 to 127 divides correctly.

Top module: `subdiv_top`

## Requirements
- R1: Both operands are captured at the first rising clock edge that samples start high after a sample with start low (the capture edge).
- R2: Changes on dividend or divisor after the capture edge have no effect on the result of the current operation. Only the next capture edge takes new values.
- R3: One trial subtraction happens per clock after the capture edge. For a non-zero divisor with quotient Q, done is first high after Q+2 rising edges, counted from and including the capture edge. The failing trial, the one whose subtractor carry-out is 0, ends the loop.
- R4: For a divisor from 1 to 127, quotient equals the integer part of dividend divided by divisor, over all 8-bit dividends.
- R5: For a divisor from 1 to 127, remainder equals dividend modulo divisor, and it is always less than the captured divisor.
- R6: Once done is high, it stays high at every edge at which start is still sampled high.
- R7: A divisor of 0 sets div_zero and raises done after 1 edge (the capture edge), with quotient and remainder both 0.
- R8: After completion, done goes low at the first edge that samples start low.
- R9: While reset is asserted (rst_n low), done, div_zero, quotient and remainder are all 0.
- R10: Every new capture edge with a non-zero divisor clears div_zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Low while operands are set up; a rise launches a division |
| dividend | input | 8 | Unsigned dividend |
| divisor | input | 7 | Unsigned divisor |
| quotient | output | 8 | Count of successful subtractions |
| remainder | output | 7 | Value left after the last successful subtraction |
| done | output | 1 | Result valid; held while start remains high |
| div_zero | output | 1 | Division by zero was requested |

## Verification
Results arrive a fixed number of edges after the capture edge: Q+2 edges for a non-zero divisor, or 1 edge for a zero divisor. Once start is lowered, done drops one edge later. The bench counts rising edges with its own counter and notes the count when it raises start. When the monitor sees done rise, it checks the elapsed count against the latency queued with the expected quotient and remainder. All ports are sampled at falling edges, so each check looks at settled values from the edge just before. The operands are scrambled one cycle after capture to show that the latched values are the ones used.

// File: rtl/subdiv_pkg.sv
package subdiv_pkg;

  typedef enum logic [1:0] {
    SD_IDLE = 2'd0,
    SD_RUN  = 2'd1,
    SD_FIN  = 2'd2
  } sd_state_t;

  // Carry of one full-adder cell.
  function automatic logic carry3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Sum bit of one full-adder cell.
  function automatic logic sum3(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

endpackage

// File: rtl/sd_trial_sub.sv
// Ripple subtractor computing minuend + ~subtrahend + 1.
// carry_out high means the difference is non-negative.
module sd_trial_sub #(
  parameter int A_W = 8,
  parameter int B_W = 7
) (
  input  logic [A_W-1:0] minuend,
  input  logic [B_W-1:0] subtrahend,
  output logic [A_W-1:0] diff,
  output logic           carry_out
);
  import subdiv_pkg::*;

  logic [A_W-1:0] sub_ext;
  logic [A_W:0]   chain;

  assign sub_ext  = A_W'(subtrahend);
  assign chain[0] = 1'b1;

  for (genvar i = 0; i < A_W; i++) begin : g_cell
    assign diff[i]    = sum3(minuend[i], ~sub_ext[i], chain[i]);
    assign chain[i+1] = carry3(minuend[i], ~sub_ext[i], chain[i]);
  end

  assign carry_out = chain[A_W];
endmodule

// File: rtl/sd_regs.sv
// Running value, captured divisor and quotient counter.
module sd_regs #(
  parameter int A_W = 8,
  parameter int B_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           load_zero,
  input  logic           step,
  input  logic [A_W-1:0] dividend,
  input  logic [B_W-1:0] divisor,
  input  logic [A_W-1:0] diff,
  output logic [A_W-1:0] run_val,
  output logic [B_W-1:0] divr_q,
  output logic [A_W-1:0] quot
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_val <= '0;
      divr_q  <= '0;
      quot    <= '0;
    end else if (load) begin
      run_val <= load_zero ? '0 : dividend;
      divr_q  <= divisor;
      quot    <= '0;
    end else if (step) begin
      run_val <= diff;
      quot    <= quot + A_W'(1);
    end
  end
endmodule

// File: rtl/sd_ctrl.sv
// Start-edge detection and loop sequencing.
module sd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic divisor_zero,
  input  logic trial_ok,
  output logic start_rise,
  output logic load,
  output logic load_zero,
  output logic step,
  output logic busy,
  output logic done,
  output logic err
);
  import subdiv_pkg::*;

  sd_state_t state, state_nx;
  logic      start_q;
  logic      err_nx;

  assign start_rise = start & ~start_q;
  assign busy       = (state == SD_RUN);
  assign done       = (state == SD_FIN);

  always_comb begin
    state_nx  = state;
    err_nx    = err;
    load      = 1'b0;
    load_zero = 1'b0;
    step      = 1'b0;
    unique case (state)
      SD_IDLE: begin
        if (start_rise) begin
          load      = 1'b1;
          load_zero = divisor_zero;
          err_nx    = divisor_zero;
          state_nx  = divisor_zero ? SD_FIN : SD_RUN;
        end
      end
      SD_RUN: begin
        if (trial_ok) step = 1'b1;
        else          state_nx = SD_FIN;
      end
      SD_FIN: begin
        if (!start) state_nx = SD_IDLE;
      end
      default: state_nx = SD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SD_IDLE;
      start_q <= 1'b0;
      err     <= 1'b0;
    end else begin
      state   <= state_nx;
      start_q <= start;
      err     <= err_nx;
    end
  end
endmodule

// File: rtl/subdiv_top.sv
module subdiv_top #(
  parameter int A_W = 8,
  parameter int B_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [A_W-1:0] dividend,
  input  logic [B_W-1:0] divisor,
  output logic [A_W-1:0] quotient,
  output logic [B_W-1:0] remainder,
  output logic           done,
  output logic           div_zero
);
  // Named internal events, observed by the bound checker.
  logic           start_rise;
  logic           load, load_zero, step, busy;
  logic           trial_ok, trial_end;
  logic           divisor_zero;
  logic [A_W-1:0] run_val, diff;
  logic [B_W-1:0] divr_q;

  assign divisor_zero = (divisor == '0);
  assign trial_end    = busy & ~trial_ok;

  sd_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .divisor_zero (divisor_zero),
    .trial_ok     (trial_ok),
    .start_rise   (start_rise),
    .load         (load),
    .load_zero    (load_zero),
    .step         (step),
    .busy         (busy),
    .done         (done),
    .err          (div_zero)
  );

  sd_trial_sub #(.A_W(A_W), .B_W(B_W)) u_sub (
    .minuend    (run_val),
    .subtrahend (divr_q),
    .diff       (diff),
    .carry_out  (trial_ok)
  );

  sd_regs #(.A_W(A_W), .B_W(B_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_zero (load_zero),
    .step      (step),
    .dividend  (dividend),
    .divisor   (divisor),
    .diff      (diff),
    .run_val   (run_val),
    .divr_q    (divr_q),
    .quot      (quotient)
  );

  // After the failing trial the running value is below the divisor.
  assign remainder = run_val[B_W-1:0];
endmodule

// File: rtl/subdiv_chk.sv
module subdiv_chk #(
  parameter int A_W = 8,
  parameter int B_W = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           done,
  input logic           div_zero,
  input logic           step,
  input logic           busy,
  input logic           trial_end,
  input logic [A_W-1:0] quotient,
  input logic [B_W-1:0] remainder,
  input logic [B_W-1:0] divr_q
);
  p_latched_divisor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || done) |=> $stable(divr_q));

  p_end_on_negative_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trial_end |=> done);

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (quotient == $past(quotient) + A_W'(1)));

  p_rem_below_divisor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> (remainder < divr_q));

  p_done_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done);

  p_zero_results_r7: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> (quotient == '0 && remainder == '0));

  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);
endmodule

bind subdiv_top subdiv_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .div_zero  (div_zero),
  .step      (step),
  .busy      (busy),
  .trial_end (trial_end),
  .quotient  (quotient),
  .remainder (remainder),
  .divr_q    (divr_q)
);

// File: tb/subdiv_top_test.sv
module subdiv_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] dividend;
  logic [6:0] divisor;
  logic [7:0] quotient;
  logic [6:0] remainder;
  logic       done;
  logic       div_zero;

  always #10 clk = ~clk;

  subdiv_top uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder),
    .done      (done),
    .div_zero  (div_zero)
  );

  typedef struct {
    int q;
    int r;
    bit err;
    int lat;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   start_cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  logic done_d = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: on each rise of done, pop the oldest expectation and compare.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done === 1'b1 && done_d !== 1'b1) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R3 done without pending operation", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(int'(quotient) == e.q, "R1 R2 R4 quotient", int'(quotient), e.q);
        check(int'(remainder) == e.r, "R5 remainder", int'(remainder), e.r);
        check(div_zero == e.err, "R7 R10 div_zero", int'(div_zero), int'(e.err));
        check((cyc - start_cyc) == e.lat, "R3 latency in edges", cyc - start_cyc, e.lat);
      end
    end
    done_d = done;
  end

  // Driver: queue the expectation, launch, scramble inputs, hold, release.
  task automatic run_div(input int a, input int d, input int hold);
    exp_t e;
    if (d == 0) begin
      e.q = 0; e.r = 0; e.err = 1'b1; e.lat = 1;
    end else begin
      e.q = a / d; e.r = a % d; e.err = 1'b0; e.lat = (a / d) + 2;
    end
    sbq.push_back(e);
    @(negedge clk);
    dividend  = 8'(a);
    divisor   = 7'(d);
    start     = 1'b1;
    start_cyc = cyc;
    @(negedge clk);
    dividend = ~8'(a);
    divisor  = 7'(d) ^ 7'h55;
    while (done !== 1'b1) @(negedge clk);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(done === 1'b1, "R6 done held with start high", int'(done), 1);
    end
    start = 1'b0;
    @(negedge clk);
    check(done === 1'b0, "R8 done cleared after start low", int'(done), 0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    wait (cyc >= 190000);
    check(1'b0, "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int dlist[11];
    dlist = '{1, 2, 3, 5, 7, 10, 16, 31, 64, 99, 127};
    rst_n    = 1'b0;
    start    = 1'b0;
    dividend = 8'd0;
    divisor  = 7'd0;
    repeat (3) @(negedge clk);
    check(done === 1'b0, "R9 reset done", int'(done), 0);
    check(div_zero === 1'b0, "R9 reset div_zero", int'(div_zero), 0);
    check(quotient === 8'd0, "R9 reset quotient", int'(quotient), 0);
    check(remainder === 7'd0, "R9 reset remainder", int'(remainder), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Corner cases: zero divisor, then a normal division clearing the flag.
    run_div(200, 0, 3);   // R7
    run_div(45, 7, 3);    // R10
    run_div(0, 0, 1);     // R7
    run_div(255, 1, 2);   // longest loop
    run_div(98, 99, 1);   // divisor above dividend
    run_div(99, 99, 1);   // exact
    run_div(0, 5, 1);

    // Every dividend for a spread of divisors.
    foreach (dlist[j])
      for (int a = 0; a < 256; a++)
        run_div(a, dlist[j], 1);

    // Every divisor for two dividends.
    for (int d = 1; d < 128; d++) begin
      run_div(255, d, 0);
      run_div(100, d, 0);
    end

    repeat (2) @(negedge clk);
    check(sbq.size() == 0, "R3 every operation completed", sbq.size(), 0);
    summary();
    $finish;
  end
endmodule